// File: doc/BRIEF.md
# Dispatch Resource Credit Limiter

This block decides, for each hardware thread and in every cycle, how many instructions the rename stage may hand onward. It keeps the most recent free-entry counts reported by three downstream structures: the reorder buffer, the issue queue and the load/store queue. Each count is corrected by the work that has been renamed but not yet dispatched. This gives a speculative credit for each structure. The smallest credit sets the group size.

When the smallest credit is zero or negative, the block asks for a full stall. When it is positive but smaller than the number of waiting instructions, the block lets a partial group through and asks for a stall afterwards. In both cases it names the limiting structure with a 2-bit code and pulses a full-event line for that structure. The grant is also capped at the rename width. The block keeps a per-thread in-flight counter that rises by the renamed count and falls by the dispatched count. It also tracks an empty flag for the reorder buffer.

Top module: `dcl_credit_limiter`

## Requirements
- R1: The reorder-buffer credit and the issue-queue credit are each the stored free count minus (in-flight count minus `disp_total_i` of this cycle), computed as signed values, so a negative credit is possible.
- R2: The load/store-queue credit subtracts (in-flight count minus `disp_lsq_i`), using the load/store dispatch count in place of the total dispatch count.
- R3: The limiting structure is the one with the minimum credit. `lim_o` is 00 for the reorder buffer, 01 for the issue queue and 10 for the load/store queue. The reorder buffer is chosen by default. The issue queue replaces it only when its credit is strictly smaller. The load/store queue then replaces the current choice only when its credit is strictly smaller again.
- R4: If `avail_i` > 0 and the minimum credit is ≤ 0, then `block_o` = 1, `allow_o` = 0, `throttle_o` = 0, and only the full-event line of the limiting structure is high.
- R5: If `avail_i` > 0 and 0 < minimum credit < `avail_i`, then `throttle_o` = 1, `block_o` = 0, `allow_o` = min(minimum credit, RENAME_W), and only the full-event line of the limiting structure is high.
- R6: If the minimum credit is ≥ `avail_i`, then `allow_o` = min(`avail_i`, RENAME_W), and `block_o`, `throttle_o` and all full-event lines are low.
- R7: If `avail_i` = 0, then `allow_o` = 0, and `block_o`, `throttle_o` and all full-event lines are low, whatever the credits are.
- R8: A stored free count is overwritten only in a cycle where its own update strobe is high. The new value takes effect in the credits from the following cycle. Without the strobe, the input value has no effect.
- R9: `rob_empty_o` takes `rob_empty_i` at each clock edge where the reorder-buffer strobe is high, and holds its value otherwise.
- R10: The in-flight count changes at each clock edge by +`renamed_i` − `disp_total_i`. It is clamped at 0 from below and at its maximum from above.
- R11: After reset, all stored free counts are 0, the in-flight count is 0 and `rob_empty_o` is 1. A thread with waiting instructions is therefore blocked on the reorder buffer.
- R12: Each thread's outputs depend only on that thread's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_free_i | input | THREADS*FREE_W | Reported reorder-buffer free entries per thread |
| rob_upd_i | input | THREADS | Strobe that loads `rob_free_i` and `rob_empty_i` |
| rob_empty_i | input | THREADS | Reported reorder-buffer empty state |
| iq_free_i | input | THREADS*FREE_W | Reported issue-queue free entries |
| iq_upd_i | input | THREADS | Strobe that loads `iq_free_i` |
| lsq_free_i | input | THREADS*FREE_W | Reported load/store-queue free entries |
| lsq_upd_i | input | THREADS | Strobe that loads `lsq_free_i` |
| disp_total_i | input | THREADS*GRP_W | Instructions dispatched this cycle |
| disp_lsq_i | input | THREADS*GRP_W | Instructions dispatched to the load/store queue this cycle |
| renamed_i | input | THREADS*GRP_W | Instructions renamed this cycle |
| avail_i | input | THREADS*GRP_W | Instructions waiting to be renamed |
| allow_o | output | THREADS*GRP_W | Number of instructions allowed this cycle |
| block_o | output | THREADS | Full stall request |
| throttle_o | output | THREADS | Partial group; stall after this cycle |
| lim_o | output | THREADS*2 | Limiting structure code |
| rob_full_o | output | THREADS | Reorder-buffer full event |
| iq_full_o | output | THREADS | Issue-queue full event |
| lsq_full_o | output | THREADS | Load/store-queue full event |
| rob_empty_o | output | THREADS | Stored reorder-buffer empty flag |
| inflight_o | output | THREADS*INF_W | Renamed-but-undispatched count |

## Verification
A wrong stored free count or in-flight value has no direct port of its own. It surfaces in the cycle after the corrupting edge, as a changed `allow_o`, a spurious or missing `block_o`/`throttle_o`, or a different `lim_o` code. A faulty in-flight counter also shows directly on `inflight_o` one edge after the bad update. A tie-break error only shows when two credits are equal. For that reason the stimulus places equal credits in front of each comparison.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  // Code naming the structure that limits the group (R3)
  typedef enum logic [1:0] {
    LIM_ROB = 2'b00,
    LIM_IQ  = 2'b01,
    LIM_LSQ = 2'b10
  } lim_e;

  // Bit positions inside the full-event vector
  localparam int FULL_ROB_BIT = 2;
  localparam int FULL_IQ_BIT  = 1;
  localparam int FULL_LSQ_BIT = 0;

endpackage

// File: rtl/dcl_credit_store.sv
module dcl_credit_store #(
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREE_W-1:0] rob_in,
  input  logic              rob_upd,
  input  logic              empty_in,
  input  logic [FREE_W-1:0] iq_in,
  input  logic              iq_upd,
  input  logic [FREE_W-1:0] lsq_in,
  input  logic              lsq_upd,
  output logic [FREE_W-1:0] rob_q,
  output logic [FREE_W-1:0] iq_q,
  output logic [FREE_W-1:0] lsq_q,
  output logic              empty_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rob_q   <= '0;
      iq_q    <= '0;
      lsq_q   <= '0;
      empty_q <= 1'b1;
    end else begin
      if (rob_upd) begin
        rob_q   <= rob_in;
        empty_q <= empty_in;
      end
      if (iq_upd)  iq_q  <= iq_in;
      if (lsq_upd) lsq_q <= lsq_in;
    end
  end

  // R8: without a strobe the stored counts hold
  p_rob_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rob_upd |=> $stable(rob_q));
  p_iq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !iq_upd |=> $stable(iq_q));
  p_lsq_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lsq_upd |=> lsq_q == $past(lsq_in));
  // R9: empty flag moves only with the reorder-buffer strobe
  p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rob_upd |=> $stable(empty_q));

endmodule

// File: rtl/dcl_inflight.sv
module dcl_inflight #(
  parameter int GRP_W = 3,
  parameter int INF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] renamed,
  input  logic [GRP_W-1:0] disp,
  output logic [INF_W-1:0] count
);

  localparam int SUM_W = INF_W + 2;
  localparam int MAX_V = (1 << INF_W) - 1;
  typedef logic signed [SUM_W-1:0] sum_t;

  // Clamped step of the in-flight counter (R10)
  function automatic logic [INF_W-1:0] step(input logic [INF_W-1:0] cur,
                                            input logic [GRP_W-1:0] up,
                                            input logic [GRP_W-1:0] down);
    sum_t s;
    s = sum_t'({2'b00, cur}) + sum_t'({{(SUM_W-GRP_W){1'b0}}, up})
      - sum_t'({{(SUM_W-GRP_W){1'b0}}, down});
    if (s < 0)                 s = '0;
    else if (s > sum_t'(MAX_V)) s = sum_t'(MAX_V);
    return s[INF_W-1:0];
  endfunction

  logic [INF_W-1:0] count_nxt;
  assign count_nxt = step(count, renamed, disp);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  // R10: direction of change follows the inputs
  p_infl_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (renamed == '0 && disp == '0) |=> $stable(count));
  p_infl_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp == '0) |=> count >= $past(count));
  p_infl_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (renamed == '0) |=> count <= $past(count));

endmodule

// File: rtl/dcl_credit_pick.sv
module dcl_credit_pick
  import dcl_pkg::*;
#(
  parameter int FREE_W   = 6,
  parameter int INF_W    = 7,
  parameter int GRP_W    = 3,
  parameter int RENAME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREE_W-1:0] rob_free,
  input  logic [FREE_W-1:0] iq_free,
  input  logic [FREE_W-1:0] lsq_free,
  input  logic [INF_W-1:0]  inflight,
  input  logic [GRP_W-1:0]  disp_tot,
  input  logic [GRP_W-1:0]  disp_lsq,
  input  logic [GRP_W-1:0]  avail,
  output logic [GRP_W-1:0]  allow,
  output logic              block,
  output logic              throttle,
  output lim_e              lim,
  output logic [2:0]        full
);

  localparam int CRED_W = INF_W + 2;
  typedef logic signed [CRED_W-1:0] cred_t;

  // Speculative credit: reported free minus undispatched in-flight (R1, R2)
  function automatic cred_t credit(input logic [FREE_W-1:0] f,
                                   input logic [INF_W-1:0]  n,
                                   input logic [GRP_W-1:0]  d);
    cred_t fs, ns, ds;
    fs = cred_t'({{(CRED_W-FREE_W){1'b0}}, f});
    ns = cred_t'({{(CRED_W-INF_W){1'b0}}, n});
    ds = cred_t'({{(CRED_W-GRP_W){1'b0}}, d});
    return fs - (ns - ds);
  endfunction

  // Grant: smallest of waiting count, credit and rename width (R5, R6)
  function automatic logic [GRP_W-1:0] grant(input cred_t m,
                                             input logic [GRP_W-1:0] a);
    cred_t g;
    g = cred_t'({{(CRED_W-GRP_W){1'b0}}, a});
    if (m < g)                    g = m;
    if (g > cred_t'(RENAME_W))    g = cred_t'(RENAME_W);
    if (g < 0)                    g = '0;
    return g[GRP_W-1:0];
  endfunction

  cred_t c_rob, c_iq, c_lsq, c_min;
  cred_t avail_s;
  logic  has_work, short_none, short_some, limited;

  assign c_rob   = credit(rob_free, inflight, disp_tot);
  assign c_iq    = credit(iq_free,  inflight, disp_tot);
  assign c_lsq   = credit(lsq_free, inflight, disp_lsq);
  assign avail_s = cred_t'({{(CRED_W-GRP_W){1'b0}}, avail});

  // Fixed tie-break: reorder buffer, then strictly smaller replaces (R3)
  always_comb begin
    c_min = c_rob;
    lim   = LIM_ROB;
    if (c_iq < c_min) begin
      c_min = c_iq;
      lim   = LIM_IQ;
    end
    if (c_lsq < c_min) begin
      c_min = c_lsq;
      lim   = LIM_LSQ;
    end
  end

  assign has_work   = (avail != '0);
  assign short_none = has_work && (c_min <= 0);
  assign short_some = has_work && (c_min > 0) && (c_min < avail_s);
  assign limited    = short_none || short_some;

  assign block    = short_none;
  assign throttle = short_some;
  assign allow    = (short_none || !has_work) ? '0 : grant(c_min, avail);

  always_comb begin
    full = 3'b000;
    if (limited) begin
      unique case (lim)
        LIM_ROB: full[FULL_ROB_BIT] = 1'b1;
        LIM_IQ:  full[FULL_IQ_BIT]  = 1'b1;
        default: full[FULL_LSQ_BIT] = 1'b1;
      endcase
    end
  end

  // R4: a full stall grants nothing
  p_block_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> (allow == '0 && !throttle));
  // R5/R6: never beyond the waiting count or the rename width
  p_allow_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (allow <= avail) && (int'(allow) <= RENAME_W));
  // R4/R5: at most one full event, present exactly when limited
  p_full_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(full) && ((full != 3'b000) == (block || throttle)));
  // R3: a load/store choice means it is strictly below both others
  p_lsq_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lim == LIM_LSQ) |-> (c_lsq < c_rob && c_lsq < c_iq));
  // R7: nothing waiting, nothing signalled
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (avail == '0) |-> (!block && !throttle && full == 3'b000));

endmodule

// File: rtl/dcl_credit_limiter.sv
module dcl_credit_limiter
  import dcl_pkg::*;
#(
  parameter int THREADS  = 2,
  parameter int FREE_W   = 6,
  parameter int GRP_W    = 3,
  parameter int RENAME_W = 4,
  parameter int INF_W    = FREE_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [THREADS*FREE_W-1:0] rob_free_i,
  input  logic [THREADS-1:0]        rob_upd_i,
  input  logic [THREADS-1:0]        rob_empty_i,
  input  logic [THREADS*FREE_W-1:0] iq_free_i,
  input  logic [THREADS-1:0]        iq_upd_i,
  input  logic [THREADS*FREE_W-1:0] lsq_free_i,
  input  logic [THREADS-1:0]        lsq_upd_i,
  input  logic [THREADS*GRP_W-1:0]  disp_total_i,
  input  logic [THREADS*GRP_W-1:0]  disp_lsq_i,
  input  logic [THREADS*GRP_W-1:0]  renamed_i,
  input  logic [THREADS*GRP_W-1:0]  avail_i,
  output logic [THREADS*GRP_W-1:0]  allow_o,
  output logic [THREADS-1:0]        block_o,
  output logic [THREADS-1:0]        throttle_o,
  output logic [THREADS*2-1:0]      lim_o,
  output logic [THREADS-1:0]        rob_full_o,
  output logic [THREADS-1:0]        iq_full_o,
  output logic [THREADS-1:0]        lsq_full_o,
  output logic [THREADS-1:0]        rob_empty_o,
  output logic [THREADS*INF_W-1:0]  inflight_o
);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [FREE_W-1:0] rob_q, iq_q, lsq_q;
    logic [INF_W-1:0]  infl;
    lim_e              lim_t;
    logic [2:0]        full_t;

    dcl_credit_store #(.FREE_W(FREE_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rob_in   (rob_free_i[t*FREE_W +: FREE_W]),
      .rob_upd  (rob_upd_i[t]),
      .empty_in (rob_empty_i[t]),
      .iq_in    (iq_free_i[t*FREE_W +: FREE_W]),
      .iq_upd   (iq_upd_i[t]),
      .lsq_in   (lsq_free_i[t*FREE_W +: FREE_W]),
      .lsq_upd  (lsq_upd_i[t]),
      .rob_q    (rob_q),
      .iq_q     (iq_q),
      .lsq_q    (lsq_q),
      .empty_q  (rob_empty_o[t])
    );

    dcl_inflight #(.GRP_W(GRP_W), .INF_W(INF_W)) u_infl (
      .clk     (clk),
      .rst_n   (rst_n),
      .renamed (renamed_i[t*GRP_W +: GRP_W]),
      .disp    (disp_total_i[t*GRP_W +: GRP_W]),
      .count   (infl)
    );

    dcl_credit_pick #(
      .FREE_W(FREE_W), .INF_W(INF_W), .GRP_W(GRP_W), .RENAME_W(RENAME_W)
    ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .rob_free (rob_q),
      .iq_free  (iq_q),
      .lsq_free (lsq_q),
      .inflight (infl),
      .disp_tot (disp_total_i[t*GRP_W +: GRP_W]),
      .disp_lsq (disp_lsq_i[t*GRP_W +: GRP_W]),
      .avail    (avail_i[t*GRP_W +: GRP_W]),
      .allow    (allow_o[t*GRP_W +: GRP_W]),
      .block    (block_o[t]),
      .throttle (throttle_o[t]),
      .lim      (lim_t),
      .full     (full_t)
    );

    assign lim_o[t*2 +: 2]           = lim_t;
    assign rob_full_o[t]             = full_t[FULL_ROB_BIT];
    assign iq_full_o[t]              = full_t[FULL_IQ_BIT];
    assign lsq_full_o[t]             = full_t[FULL_LSQ_BIT];
    assign inflight_o[t*INF_W +: INF_W] = infl;
  end

endmodule

// File: tb/dcl_credit_limiter_tb.sv
module dcl_credit_limiter_tb;

  localparam int T = 2, FW = 6, GW = 3, RW = 4, IW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [T*FW-1:0] rob_free_i = '0, iq_free_i = '0, lsq_free_i = '0;
  logic [T-1:0] rob_upd_i = '0, rob_empty_i = '1, iq_upd_i = '0, lsq_upd_i = '0;
  logic [T*GW-1:0] disp_total_i = '0, disp_lsq_i = '0, renamed_i = '0, avail_i = '0;
  logic [T*GW-1:0] allow_o;
  logic [T-1:0] block_o, throttle_o, rob_full_o, iq_full_o, lsq_full_o, rob_empty_o;
  logic [T*2-1:0] lim_o;
  logic [T*IW-1:0] inflight_o;

  always #10 clk = ~clk;  // 50 MHz

  dcl_credit_limiter #(.THREADS(T), .FREE_W(FW), .GRP_W(GW), .RENAME_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rob_free_i(rob_free_i), .rob_upd_i(rob_upd_i), .rob_empty_i(rob_empty_i),
    .iq_free_i(iq_free_i), .iq_upd_i(iq_upd_i),
    .lsq_free_i(lsq_free_i), .lsq_upd_i(lsq_upd_i),
    .disp_total_i(disp_total_i), .disp_lsq_i(disp_lsq_i),
    .renamed_i(renamed_i), .avail_i(avail_i),
    .allow_o(allow_o), .block_o(block_o), .throttle_o(throttle_o), .lim_o(lim_o),
    .rob_full_o(rob_full_o), .iq_full_o(iq_full_o), .lsq_full_o(lsq_full_o),
    .rob_empty_o(rob_empty_o), .inflight_o(inflight_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Full event vector of a thread as {rob,iq,lsq}
  function automatic int fullv(input int t);
    return {29'd0, rob_full_o[t], iq_full_o[t], lsq_full_o[t]};
  endfunction

  // Thread 0 vectors: {rob,iq,lsq,avail | allow,block,throttle,lim,full}
  // In-flight is 0 and nothing is dispatched, so credits equal the counts.
  localparam logic [30:0] VEC [12] = '{
    {6'd10, 6'd10, 6'd10, 3'd3, 3'd3, 1'b0, 1'b0, 2'd0, 3'b000}, // R3 triple tie, R6
    {6'd10, 6'd10, 6'd10, 3'd7, 3'd4, 1'b0, 1'b0, 2'd0, 3'b000}, // R6 width cap
    {6'd5,  6'd3,  6'd8,  3'd4, 3'd3, 1'b0, 1'b1, 2'd1, 3'b010}, // R5 issue queue
    {6'd5,  6'd5,  6'd2,  3'd4, 3'd2, 1'b0, 1'b1, 2'd2, 3'b001}, // R5 load/store
    {6'd4,  6'd4,  6'd9,  3'd2, 3'd2, 1'b0, 1'b0, 2'd0, 3'b000}, // R3 tie rob/iq
    {6'd0,  6'd7,  6'd7,  3'd1, 3'd0, 1'b1, 1'b0, 2'd0, 3'b100}, // R4 rob block
    {6'd6,  6'd0,  6'd0,  3'd3, 3'd0, 1'b1, 1'b0, 2'd1, 3'b010}, // R3 tie iq/lsq, R4
    {6'd6,  6'd6,  6'd0,  3'd5, 3'd0, 1'b1, 1'b0, 2'd2, 3'b001}, // R4 lsq block
    {6'd3,  6'd9,  6'd9,  3'd0, 3'd0, 1'b0, 1'b0, 2'd0, 3'b000}, // R7 idle
    {6'd2,  6'd9,  6'd9,  3'd2, 3'd2, 1'b0, 1'b0, 2'd0, 3'b000}, // R6 equal
    {6'd9,  6'd2,  6'd9,  3'd3, 3'd2, 1'b0, 1'b1, 2'd1, 3'b010}, // R5
    {6'd20, 6'd30, 6'd6,  3'd7, 3'd4, 1'b0, 1'b1, 2'd2, 3'b001}  // R5 width cap
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: reset state, both threads waiting
    avail_i = {3'd2, 3'd2};
    #5;
    for (int t = 0; t < T; t++) begin
      chk("R11 block", block_o[t], 1);
      chk("R11 allow", int'(allow_o[t*GW +: GW]), 0);
      chk("R11 lim", int'(lim_o[t*2 +: 2]), 0);
      chk("R11 full", fullv(t), 4);
      chk("R11 empty", rob_empty_o[t], 1);
      chk("R11 inflight", int'(inflight_o[t*IW +: IW]), 0);
    end

    // Table walk on thread 0; thread 1 stays idle
    avail_i = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      rob_free_i[FW-1:0] = VEC[i][30:25];
      iq_free_i[FW-1:0]  = VEC[i][24:19];
      lsq_free_i[FW-1:0] = VEC[i][18:13];
      rob_upd_i[0] = 1'b1; iq_upd_i[0] = 1'b1; lsq_upd_i[0] = 1'b1;
      avail_i[GW-1:0] = '0;
      @(negedge clk);
      rob_upd_i[0] = 1'b0; iq_upd_i[0] = 1'b0; lsq_upd_i[0] = 1'b0;
      avail_i[GW-1:0] = VEC[i][12:10];
      #5;
      chk("R5/R6 allow", int'(allow_o[GW-1:0]), int'(VEC[i][9:7]));
      chk("R4 block", block_o[0], VEC[i][6]);
      chk("R5 throttle", throttle_o[0], VEC[i][5]);
      chk("R3 lim", int'(lim_o[1:0]), int'(VEC[i][4:3]));
      chk("R4/R5 full", fullv(0), int'(VEC[i][2:0]));
      chk("R12 other thread quiet", block_o[1], 0);
    end

    // R8: strobe cycle still uses the old count (20,30,6 stored)
    @(negedge clk);
    rob_free_i[FW-1:0] = 6'd0; rob_upd_i[0] = 1'b1; avail_i[GW-1:0] = 3'd3;
    #5;
    chk("R8 old value in strobe cycle", int'(allow_o[GW-1:0]), 3);
    chk("R8 no block yet", block_o[0], 0);
    @(negedge clk);
    rob_upd_i[0] = 1'b0; rob_free_i[FW-1:0] = 6'd40; rob_empty_i[0] = 1'b0;
    #5;
    chk("R8 new value applied", block_o[0], 1);
    chk("R8 lim rob", int'(lim_o[1:0]), 0);
    @(negedge clk);
    #5;
    chk("R8 unstrobed input ignored", block_o[0], 1);
    chk("R9 empty held without strobe", rob_empty_o[0], 1);
    avail_i[GW-1:0] = '0;

    // Thread 1: counts 8,8,8 and empty flag cleared with strobe
    @(negedge clk);
    rob_free_i[2*FW-1:FW] = 6'd8; iq_free_i[2*FW-1:FW] = 6'd8; lsq_free_i[2*FW-1:FW] = 6'd8;
    rob_upd_i[1] = 1'b1; iq_upd_i[1] = 1'b1; lsq_upd_i[1] = 1'b1; rob_empty_i[1] = 1'b0;
    avail_i[2*GW-1:GW] = '0;
    @(negedge clk);
    rob_upd_i[1] = 1'b0; iq_upd_i[1] = 1'b0; lsq_upd_i[1] = 1'b0;
    #5;
    chk("R9 empty loaded", rob_empty_o[1], 0);

    // R10: rename 3
    @(negedge clk);
    renamed_i[2*GW-1:GW] = 3'd3;
    @(negedge clk);
    renamed_i[2*GW-1:GW] = 3'd0; avail_i[2*GW-1:GW] = 3'd7;
    #5;
    chk("R10 inflight up", int'(inflight_o[2*IW-1:IW]), 3);
    chk("R1 credit 5 throttles", throttle_o[1], 1);
    chk("R1 allow width", int'(allow_o[2*GW-1:GW]), 4);
    chk("R1 lim rob", int'(lim_o[3:2]), 0);

    // R2: two dispatched, none to the load/store queue
    @(negedge clk);
    disp_total_i[2*GW-1:GW] = 3'd2; disp_lsq_i[2*GW-1:GW] = 3'd0; avail_i[2*GW-1:GW] = 3'd6;
    #5;
    chk("R2 lim lsq", int'(lim_o[3:2]), 2);
    chk("R2 lsq full", fullv(1), 1);
    chk("R2 throttle", throttle_o[1], 1);
    @(negedge clk);
    disp_total_i[2*GW-1:GW] = 3'd0; avail_i[2*GW-1:GW] = 3'd0;
    #5;
    chk("R10 inflight down", int'(inflight_o[2*IW-1:IW]), 1);

    // R10 floor: dispatch 3 with 1 in flight
    @(negedge clk);
    disp_total_i[2*GW-1:GW] = 3'd3;
    @(negedge clk);
    disp_total_i[2*GW-1:GW] = 3'd0;
    #5;
    chk("R10 floor at zero", int'(inflight_o[2*IW-1:IW]), 0);

    // R4 negative credit: rob stored 2, four in flight
    @(negedge clk);
    rob_free_i[2*FW-1:FW] = 6'd2; rob_upd_i[1] = 1'b1; renamed_i[2*GW-1:GW] = 3'd4;
    @(negedge clk);
    rob_upd_i[1] = 1'b0; renamed_i[2*GW-1:GW] = 3'd0; avail_i[2*GW-1:GW] = 3'd1;
    #5;
    chk("R4 negative credit block", block_o[1], 1);
    chk("R4 allow zero", int'(allow_o[2*GW-1:GW]), 0);
    chk("R4 rob full", fullv(1), 4);
    chk("R12 thread 0 unaffected", int'(inflight_o[IW-1:0]), 0);

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule